// File: doc/BRIEF.md
# Stereo Attenuation Code Register with Staged Commit

This block sits on the control side of a two-channel digital attenuator. A host writes it through a plain register port: an address, a 9-bit data word and a one-cycle write strobe. For each channel the block keeps two 8-bit attenuation codes. One is a staging copy that any write to the channel updates. The other is an active copy that drives the outputs. A write that sets the load bit moves codes into the active copies of both channels at once. The host can therefore stage the left and right levels separately and have them take effect on the same clock edge.

A mode register carries a shared-level bit. When that bit is set, the left active code drives both outputs. Code zero means full silence, and each channel raises its own mute flag for it. Any other code X stands for an attenuation of (X - 255) half-dB steps. A package function computes this level, and the bench restates it independently.

Top module: `stereo_atten_ctrl`

## Requirements
- R1: After a synchronous active-high reset, both staging and both active codes are 0xFF and the shared-level bit is 0. Both code outputs then read 0xFF and both mute flags are low.
- R2: A write to address 0 with data bit 8 at 0 replaces the left staging code with data bits [7:0]. The left and right outputs stay unchanged.
- R3: A write to address 1 with data bit 8 at 0 replaces the right staging code with data bits [7:0]. The left and right outputs stay unchanged.
- R4: A write to address 0 or 1 with data bit 8 at 1 makes data bits [7:0] the new staging and active code of the addressed channel. The change is visible on the outputs right after the clock edge that samples the write.
- R5: On such a committing write, the other channel's active code takes that channel's staging code on the same edge, so both channels change together. The other channel's staging code is kept.
- R6: A channel's mute flag is high exactly when its output code is 0x00.
- R7: A write to address 3 sets the shared-level mode from data bit 2. While that bit is 1, the right code output and the right mute flag follow the left active code. While it is 0, each channel shows its own active code.
- R8: The data bits of an address-3 write other than bit 2 have no effect on any output or on the codes.
- R9: Writes to addresses 2 and 4 to 7 change nothing. Cycles with the write strobe low change nothing, whatever the address and data.
- R10: The level function returns (X - 255) as a signed count of half-dB steps for every code X. It also returns a mute indication that is 1 only for X = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 9 | Write data; bit 8 is the load bit on channel addresses |
| left_code_o | output | 8 | Effective left attenuation code |
| right_code_o | output | 8 | Effective right attenuation code |
| left_mute_o | output | 1 | Left channel fully silenced |
| right_mute_o | output | 1 | Right channel fully silenced |

## Verification
The bench builds the block with its defaults: a 3-bit address, channel addresses 0 and 1, the mode register at address 3 with the shared bit at position 2, and a reset code of 0xFF. With a 3-bit address, every unused address can be written to show that it has no effect. With 8-bit codes, the level function can be swept over all 256 values. A behavioural model of staging, commit and the shared mode is compared with all four outputs on every clock, through staged-only writes, commits from either side, mute codes and mode toggles.

// File: rtl/atten_pkg.sv
package atten_pkg;

  localparam int CODE_W  = 8;
  localparam int STEPS_W = CODE_W + 2;

  typedef logic [CODE_W-1:0] code_t;

  typedef struct packed {
    logic signed [STEPS_W-1:0] steps;
    logic                      mute;
  } atten_lvl_t;

  // Half-dB step count below full scale; code 0 additionally flags silence.
  function automatic atten_lvl_t atten_level(input code_t code);
    atten_lvl_t r;
    r.steps = $signed({2'b00, code}) - $signed(STEPS_W'((1 << CODE_W) - 1));
    r.mute  = (code == '0);
    return r;
  endfunction

endpackage

// File: rtl/atten_chan_reg.sv
module atten_chan_reg
  import atten_pkg::*;
#(
  parameter code_t RESET_CODE = 8'hFF
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  chan_hit,
  input  logic  commit_evt,
  input  code_t wr_code,
  output code_t active_code
);

  code_t staging_q;
  code_t active_q;

  // Named events for the assertions
  logic stage_only_evt;
  logic self_commit_evt;
  logic peer_commit_evt;
  logic idle_evt;

  assign stage_only_evt  = chan_hit && !commit_evt;
  assign self_commit_evt = chan_hit && commit_evt;
  assign peer_commit_evt = !chan_hit && commit_evt;
  assign idle_evt        = !chan_hit && !commit_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      staging_q <= RESET_CODE;
      active_q  <= RESET_CODE;
    end else begin
      if (chan_hit) staging_q <= wr_code;
      if (commit_evt) active_q <= chan_hit ? wr_code : staging_q;
    end
  end

  assign active_code = active_q;

  a_r2_stage_keeps_active: assert property (@(posedge clk) disable iff (rst)
    stage_only_evt |=> $stable(active_q));

  a_r4_commit_takes_write: assert property (@(posedge clk) disable iff (rst)
    self_commit_evt |=> (active_q == $past(wr_code)) && (staging_q == $past(wr_code)));

  a_r5_peer_commit_moves_stage: assert property (@(posedge clk) disable iff (rst)
    peer_commit_evt |=> (active_q == $past(staging_q)) && $stable(staging_q));

  a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
    idle_evt |=> $stable(active_q) && $stable(staging_q));

endmodule

// File: rtl/atten_mode_reg.sv
module atten_mode_reg #(
  parameter int DATA_W    = 9,
  parameter int SHARE_BIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_hit,
  input  logic [DATA_W-1:0] wr_data,
  output logic              share_o
);

  logic share_q;

  always_ff @(posedge clk) begin
    if (rst)           share_q <= 1'b0;
    else if (mode_hit) share_q <= wr_data[SHARE_BIT];
  end

  assign share_o = share_q;

  a_r7_mode_tracks_bit: assert property (@(posedge clk) disable iff (rst)
    mode_hit |=> share_q == $past(wr_data[SHARE_BIT]));

  a_r9_mode_holds: assert property (@(posedge clk) disable iff (rst)
    !mode_hit |=> $stable(share_q));

endmodule

// File: rtl/atten_out_route.sv
module atten_out_route
  import atten_pkg::*;
(
  input  code_t left_act,
  input  code_t right_act,
  input  logic  share,
  output code_t left_code_o,
  output code_t right_code_o,
  output logic  left_mute_o,
  output logic  right_mute_o
);

  atten_lvl_t left_lvl;
  atten_lvl_t right_lvl;
  code_t      right_sel;

  assign right_sel = share ? left_act : right_act;
  assign left_lvl  = atten_level(left_act);
  assign right_lvl = atten_level(right_sel);

  assign left_code_o  = left_act;
  assign right_code_o = right_sel;
  assign left_mute_o  = left_lvl.mute;
  assign right_mute_o = right_lvl.mute;

endmodule

// File: rtl/stereo_atten_ctrl.sv
module stereo_atten_ctrl
  import atten_pkg::*;
#(
  parameter int    ADDR_W     = 3,
  parameter int    LEFT_ADDR  = 0,
  parameter int    RIGHT_ADDR = 1,
  parameter int    MODE_ADDR  = 3,
  parameter int    SHARE_BIT  = 2,
  parameter code_t RESET_CODE = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CODE_W:0]   wr_data,
  output logic [CODE_W-1:0] left_code_o,
  output logic [CODE_W-1:0] right_code_o,
  output logic              left_mute_o,
  output logic              right_mute_o
);

  localparam int NCH      = 2;
  localparam int DATA_W   = CODE_W + 1;
  localparam int LOAD_BIT = CODE_W;

  logic [NCH-1:0] chan_hit;
  logic           mode_hit;
  logic           commit_evt;
  logic           share;
  code_t          wr_code;
  code_t          active_code [NCH];

  assign chan_hit[0] = wr_en && (wr_addr == ADDR_W'(LEFT_ADDR));
  assign chan_hit[1] = wr_en && (wr_addr == ADDR_W'(RIGHT_ADDR));
  assign mode_hit    = wr_en && (wr_addr == ADDR_W'(MODE_ADDR));
  assign commit_evt  = (|chan_hit) && wr_data[LOAD_BIT];
  assign wr_code     = wr_data[CODE_W-1:0];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    atten_chan_reg #(.RESET_CODE(RESET_CODE)) chan_i (
      .clk        (clk),
      .rst        (rst),
      .chan_hit   (chan_hit[ch]),
      .commit_evt (commit_evt),
      .wr_code    (wr_code),
      .active_code(active_code[ch])
    );
  end

  atten_mode_reg #(.DATA_W(DATA_W), .SHARE_BIT(SHARE_BIT)) mode_i (
    .clk     (clk),
    .rst     (rst),
    .mode_hit(mode_hit),
    .wr_data (wr_data),
    .share_o (share)
  );

  atten_out_route route_i (
    .left_act    (active_code[0]),
    .right_act   (active_code[1]),
    .share       (share),
    .left_code_o (left_code_o),
    .right_code_o(right_code_o),
    .left_mute_o (left_mute_o),
    .right_mute_o(right_mute_o)
  );

  a_r1_reset_levels: assert property (@(posedge clk)
    $past(rst) |-> (left_code_o == RESET_CODE) && (share == 1'b0));

  a_r6_zero_commit_mutes: assert property (@(posedge clk) disable iff (rst)
    (chan_hit[0] && commit_evt && wr_code == '0) |=> left_mute_o);

  a_r7_shared_right_follows: assert property (@(posedge clk) disable iff (rst)
    (mode_hit && wr_data[SHARE_BIT]) |=> (right_code_o == left_code_o) &&
                                         (right_mute_o == left_mute_o));

  a_r4_hits_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({chan_hit, mode_hit}));

endmodule

// File: tb/stereo_atten_ctrl_tb_top.sv
module stereo_atten_ctrl_tb_top;
  import atten_pkg::*;

  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [8:0] wr_data;
  logic [7:0] left_code_o, right_code_o;
  logic       left_mute_o, right_mute_o;

  int n_checks = 0;
  int n_fail   = 0;

  // Reference state
  int stg [2];
  int act [2];
  int shr;

  always #10 clk = ~clk;

  stereo_atten_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .left_code_o(left_code_o), .right_code_o(right_code_o),
    .left_mute_o(left_mute_o), .right_mute_o(right_mute_o)
  );

  task automatic check(input string req, input string what, input int actual, input int expected);
    n_checks++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  task automatic model_clock();
    int a;
    int d;
    a = int'(wr_addr);
    d = int'(wr_data);
    if (rst) begin
      stg[0] = 255; stg[1] = 255; act[0] = 255; act[1] = 255; shr = 0;
    end else if (wr_en) begin
      if (a == 0 || a == 1) begin
        stg[a] = d % 256;
        if (d >= 256) begin
          act[a]     = d % 256;
          act[1 - a] = stg[1 - a];
        end
      end else if (a == 3) begin
        shr = (d / 4) % 2;
      end
    end
  endtask

  task automatic compare(input string req);
    int el;
    int er;
    el = act[0];
    er = (shr != 0) ? act[0] : act[1];
    check(req, "left code",  int'(left_code_o),  el);
    check(req, "right code", int'(right_code_o), er);
    check(req, "left mute",  int'(left_mute_o),  (el == 0) ? 1 : 0);
    check(req, "right mute", int'(right_mute_o), (er == 0) ? 1 : 0);
  endtask

  task automatic tick(input string req);
    @(posedge clk);
    model_clock();
    @(negedge clk);
    compare(req);
  endtask

  task automatic wr(input int addr, input int data, input string req);
    wr_en   = 1'b1;
    wr_addr = 3'(addr);
    wr_data = 9'(data);
    tick(req);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick("R1");
    tick("R1");
    rst = 1'b0;
    tick("R1");
  endtask

  initial begin
    #(200000 * 20);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    stg[0] = 0; stg[1] = 0; act[0] = 0; act[1] = 0; shr = 0;
    @(negedge clk);
    do_reset();                         // R1: 0xFF codes, no mute
    check("R1", "left after reset", int'(left_code_o), 255);

    wr(0, 9'h040, "R2");                // R2: left staged, outputs hold
    check("R2", "left held", int'(left_code_o), 255);
    wr(1, 9'h010, "R3");                // R3: right staged, outputs hold
    check("R3", "right held", int'(right_code_o), 255);
    wr(1, 9'h120, "R5");                // R4 right takes 0x20, R5 left takes staged 0x40
    check("R4", "right committed", int'(right_code_o), 8'h20);
    check("R5", "left from staging", int'(left_code_o), 8'h40);

    wr(0, 9'h1FE, "R4");                // R4: -0.5 dB step code
    check("R4", "left committed FE", int'(left_code_o), 8'hFE);
    check("R5", "right keeps its staging", int'(right_code_o), 8'h20);
    wr(1, 9'h1FD, "R4");
    wr(0, 9'h101, "R4");

    wr(0, 9'h100, "R6");                // R6: code zero mutes left
    check("R6", "left mute", int'(left_mute_o), 1);
    check("R6", "right not muted", int'(right_mute_o), 0);

    wr(3, 9'h004, "R7");                // R7: shared mode on
    check("R7", "right follows left mute", int'(right_mute_o), 1);
    wr(1, 9'h033, "R7");                // right staged while shared
    wr(1, 9'h155, "R7");                // right active hidden behind shared mode
    check("R7", "right still left", int'(right_code_o), 0);
    wr(3, 9'h1FB, "R8");                // R8: all other bits set, shared off
    check("R8", "right own code", int'(right_code_o), 8'h55);
    wr(3, 9'h000, "R8");

    wr(2, 9'h1AA, "R9");                // R9: unused addresses
    wr(4, 9'h111, "R9");
    wr(5, 9'h000, "R9");
    wr(6, 9'h1FF, "R9");
    wr(7, 9'h100, "R9");
    wr_en = 1'b0; wr_addr = 3'd0; wr_data = 9'h177;
    tick("R9");                         // R9: strobe low, left address with load
    check("R9", "left unchanged", int'(left_code_o), 0);
    wr_data = 9'h000;
    wr(0, 9'h180, "R9");                // commit reveals right staging untouched (0x55)
    check("R9", "right staging intact", int'(right_code_o), 8'h55);

    // Level function over all codes
    for (int x = 0; x < 256; x++) begin
      atten_lvl_t lv;
      lv = atten_level(8'(x));
      check("R10", "steps", int'(lv.steps), x - 255);
      check("R10", "mute",  int'(lv.mute),  (x == 0) ? 1 : 0);
    end

    wr(0, 9'h012, "R2");
    wr(1, 9'h1C3, "R5");
    do_reset();                         // R1 again mid-run
    check("R1", "right after reset", int'(right_code_o), 255);
    tick("R1");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule